// File: doc/BRIEF.md
# Paged DRAM Controller with Refresh

This block connects a simple request/acknowledge host port to an asynchronous DRAM whose row and column addresses share one address bus. The top four bits of a 24-bit request address pick one of sixteen chips with an active-low select. The next ten bits give the row and the low ten bits give the column. The controller first presents the row and strobes the row strobe. After a programmable delay it presents the column and strobes the column strobe. It then moves one byte, in the direction that a read/write-not input selects.

When an access ends, the row stays open. A later request to the same chip and row costs only a new column phase. A request to any other row first closes the open row and holds the row strobe high for a precharge time. An interval timer periodically raises a refresh request. The controller serves it ahead of any waiting host request. It closes an open row first, then performs a row-strobe-only cycle on every chip at once, using an internal row counter that advances after each refresh. Every delay is a parameter counted in controller clock cycles.

Top module: `paged_dram_ctrl`

## Requirements
- R1: Request address bits [23:20] select chip n by driving bit n of `dram_cs_n` low, with all other bits high. Bits [19:10] are the row and bits [9:0] are the column.
- R2: Before the row strobe falls for an access, the row address has been on `dram_addr` for at least one cycle. It is still there in the cycle the strobe falls.
- R3: The column strobe falls TRCD+1 cycles after the row strobe falls. The column address is on `dram_addr` one cycle before the fall and stays there. The column strobe is never low while the row strobe is high. An access from idle takes TRCD+TCAS+3 cycles from the cycle `req_valid` is first seen to `req_ready`.
- R4: The column strobe stays low for exactly TCAS cycles. Read data is captured on its last cycle and appears on `rsp_rdata` together with `req_ready`. `req_ready` is a pulse one cycle wide.
- R5: During the column phase of a write (`req_rd`=0), `dram_we_n` is low, `dram_dq_oe` is high and `dram_dq_out` carries the write byte. For a read (`req_rd`=1), `dram_we_n` is high and `dram_dq_oe` is low. Written bytes read back unchanged.
- R6: A request to the chip and row already open issues no row strobe. It takes TCAS+3 cycles when it is presented in the cycle `req_ready` is seen.
- R7: A request to a different chip or row raises the row strobe for at least TRP cycles before the new row opens. It takes TRP+TRCD+TCAS+5 cycles when presented in the `req_ready` cycle.
- R8: With the controller idle, refresh row strobes fall at TREFI+2 cycles after reset release and every TREFI cycles after that. During a refresh all chip selects are low and `dram_addr` shows the refresh row, which starts at 0 after reset and rises by one each time. The row strobe stays low for TRAS cycles.
- R9: A pending refresh is served before a waiting host request. An open row is closed before the refresh, so the next access pays the full row phase.
- R10: During reset, both strobes, `dram_we_n` and every chip select are high, `req_ready` is low and `dram_dq_oe` is low.
- R11: After an access with no new request, the row strobe stays low and the column strobe stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| req_valid | input | 1 | Host request present; held until `req_ready` |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_addr | input | 24 | Chip, row and column address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with `req_ready` |
| dram_cs_n | output | 16 | Active-low chip selects |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 8 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 8 | Data from the DRAM |

## Verification
The bench builds the block with TRCD=3, TCAS=2, TRP=4, TRAS=3 and TREFI=120. Because the delays differ from one another, an exchanged or off-by-one counter changes the measured idle, page-hit and page-miss latencies (8, 5 and 14 cycles). The short refresh interval lets refresh cycles fall inside the vector run, where they close open rows. It also makes it practical to present a host request in the very cycle a refresh becomes pending, and to time two consecutive idle refreshes exactly.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ASET,
    ST_ROW,
    ST_CSET,
    ST_COL,
    ST_OPEN,
    ST_PRE,
    ST_RSET,
    ST_REF
  } pdc_state_e;
endpackage

// File: rtl/pdc_addr_split.sv
module pdc_addr_split #(
  parameter int CHIP_W = 4,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  localparam int AW    = CHIP_W + ROW_W + COL_W,
  localparam int NCHIP = 1 << CHIP_W
) (
  input  logic [AW-1:0]    addr,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic [NCHIP-1:0] sel_n
);
  logic [CHIP_W-1:0] chip;

  assign chip = addr[AW-1 -: CHIP_W];
  assign row  = addr[COL_W +: ROW_W];
  assign col  = addr[COL_W-1:0];

  for (genvar g = 0; g < NCHIP; g++) begin : g_sel
    assign sel_n[g] = (chip != CHIP_W'(g));
  end
endmodule

// File: rtl/pdc_refresh.sv
module pdc_refresh #(
  parameter int TREFI = 780,
  parameter int ROW_W = 10,
  localparam int CW   = (TREFI > 1) ? $clog2(TREFI) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  output logic             pend,
  output logic [ROW_W-1:0] row
);
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             tick;

  assign tick = (cnt_q == '0);

  always_comb begin
    cnt_d  = tick ? CW'(TREFI - 1) : cnt_q - 1'b1;
    pend_d = pend_q;
    if (tick)      pend_d = 1'b1;
    else if (done) pend_d = 1'b0;
    row_d  = done ? row_q + 1'b1 : row_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CW'(TREFI - 1);
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      row_q  <= row_d;
    end
  end

  assign pend = pend_q;
  assign row  = row_q;
endmodule

// File: rtl/pdc_seq.sv
module pdc_seq
  import pdc_pkg::*;
#(
  parameter int TRCD = 2,
  parameter int TCAS = 2,
  parameter int TRP  = 2,
  parameter int TRAS = 4,
  parameter int AW   = 24,
  parameter int DW   = 8,
  localparam int M1   = (TRCD > TCAS) ? TRCD : TCAS,
  localparam int M2   = (TRP > TRAS) ? TRP : TRAS,
  localparam int MAXD = (M1 > M2) ? M1 : M2,
  localparam int CW   = $clog2(MAXD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_rd,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          page_hit,
  input  logic          ref_pend,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] lat_addr,
  output logic          ref_done,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out,
  output logic          col_phase,
  output logic          ref_phase,
  output logic          cs_active,
  output logic          ready,
  output logic [DW-1:0] rdata
);
  pdc_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ready_q, ready_d;
  logic          take, cap;
  logic [AW-1:0] addr_q;
  logic          rd_q;
  logic [DW-1:0] wdata_q, rdata_q;

  always_comb begin
    st_d     = st_q;
    cnt_d    = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    ready_d  = 1'b0;
    take     = 1'b0;
    cap      = 1'b0;
    ref_done = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ref_pend) begin
          st_d = ST_RSET;
        end else if (req_valid) begin
          take = 1'b1;
          st_d = ST_ASET;
        end
      end
      ST_ASET: begin
        st_d  = ST_ROW;
        cnt_d = CW'(TRCD - 1);
      end
      ST_ROW: if (cnt_q == '0) st_d = ST_CSET;
      ST_CSET: begin
        st_d  = ST_COL;
        cnt_d = CW'(TCAS - 1);
      end
      ST_COL: begin
        if (cnt_q == '0) begin
          st_d    = ST_OPEN;
          ready_d = 1'b1;
          cap     = rd_q;
        end
      end
      ST_OPEN: begin
        if (!ready_q) begin
          if (ref_pend || (req_valid && !page_hit)) begin
            st_d  = ST_PRE;
            cnt_d = CW'(TRP - 1);
          end else if (req_valid) begin
            take = 1'b1;
            st_d = ST_CSET;
          end
        end
      end
      ST_PRE: if (cnt_q == '0) st_d = ST_IDLE;
      ST_RSET: begin
        st_d  = ST_REF;
        cnt_d = CW'(TRAS - 1);
      end
      ST_REF: begin
        if (cnt_q == '0) begin
          st_d     = ST_PRE;
          cnt_d    = CW'(TRP - 1);
          ref_done = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      ready_q <= ready_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      addr_q  <= req_addr;
      rd_q    <= req_rd;
      wdata_q <= req_wdata;
    end
    if (cap) rdata_q <= dq_in;
  end

  assign col_phase = (st_q == ST_CSET) || (st_q == ST_COL);
  assign ref_phase = (st_q == ST_RSET) || (st_q == ST_REF);
  assign cs_active = (st_q == ST_ASET) || (st_q == ST_ROW) || (st_q == ST_OPEN) || col_phase;
  assign ras_n     = !((st_q == ST_ROW) || (st_q == ST_OPEN) || (st_q == ST_REF) || col_phase);
  assign cas_n     = (st_q != ST_COL);
  assign dq_oe     = col_phase && !rd_q;
  assign we_n      = !dq_oe;
  assign dq_out    = wdata_q;
  assign ready     = ready_q;
  assign rdata     = rdata_q;
  assign lat_addr  = addr_q;
endmodule

// File: rtl/paged_dram_ctrl.sv
module paged_dram_ctrl #(
  parameter int CHIP_W = 4,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int DW     = 8,
  parameter int TRCD   = 2,
  parameter int TCAS   = 2,
  parameter int TRP    = 2,
  parameter int TRAS   = 4,
  parameter int TREFI  = 780,
  localparam int AW    = CHIP_W + ROW_W + COL_W,
  localparam int NCHIP = 1 << CHIP_W,
  localparam int BUS_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_rd,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic [DW-1:0]    rsp_rdata,
  output logic [NCHIP-1:0] dram_cs_n,
  output logic [BUS_W-1:0] dram_addr,
  output logic             dram_ras_n,
  output logic             dram_cas_n,
  output logic             dram_we_n,
  output logic [DW-1:0]    dram_dq_out,
  output logic             dram_dq_oe,
  input  logic [DW-1:0]    dram_dq_in
);
  logic [AW-1:0]    lat_addr;
  logic [ROW_W-1:0] lat_row, ref_row;
  logic [COL_W-1:0] lat_col;
  logic [NCHIP-1:0] lat_sel_n;
  logic             page_hit, ref_pend, ref_done;
  logic             col_phase, ref_phase, cs_active;

  assign page_hit = (req_addr[AW-1:COL_W] == lat_addr[AW-1:COL_W]);

  pdc_addr_split #(.CHIP_W(CHIP_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .addr  (lat_addr),
    .row   (lat_row),
    .col   (lat_col),
    .sel_n (lat_sel_n)
  );

  pdc_refresh #(.TREFI(TREFI), .ROW_W(ROW_W)) u_refresh (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (ref_done),
    .pend  (ref_pend),
    .row   (ref_row)
  );

  pdc_seq #(
    .TRCD(TRCD), .TCAS(TCAS), .TRP(TRP), .TRAS(TRAS), .AW(AW), .DW(DW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_rd    (req_rd),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .page_hit  (page_hit),
    .ref_pend  (ref_pend),
    .dq_in     (dram_dq_in),
    .lat_addr  (lat_addr),
    .ref_done  (ref_done),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .dq_oe     (dram_dq_oe),
    .dq_out    (dram_dq_out),
    .col_phase (col_phase),
    .ref_phase (ref_phase),
    .cs_active (cs_active),
    .ready     (req_ready),
    .rdata     (rsp_rdata)
  );

  always_comb begin
    if (ref_phase)      dram_addr = BUS_W'(ref_row);
    else if (col_phase) dram_addr = BUS_W'(lat_col);
    else                dram_addr = BUS_W'(lat_row);
  end

  assign dram_cs_n = ref_phase ? '0 : (cs_active ? lat_sel_n : '1);
endmodule

// File: rtl/paged_dram_ctrl_chk.sv
module paged_dram_ctrl_chk #(
  parameter int CHIP_W = 4,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int TRP    = 2,
  parameter int TCAS   = 2,
  localparam int NCHIP = 1 << CHIP_W,
  localparam int BUS_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             dq_oe,
  input logic [BUS_W-1:0] addr,
  input logic [NCHIP-1:0] cs_n,
  input logic             ready
);
  int unsigned hi_cnt;
  int unsigned lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= TRP;
      lo_cnt <= 0;
    end else begin
      hi_cnt <= ras_n ? ((hi_cnt < TRP) ? hi_cnt + 1 : hi_cnt) : 0;
      lo_cnt <= cas_n ? 0 : lo_cnt + 1;
    end
  end

  assert_cas_inside_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  assert_row_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(addr));
  assert_col_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $stable(addr));
  assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  assert_cas_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> (lo_cnt == TCAS));
  assert_precharge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= TRP));
  assert_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (($countones(~cs_n) == 1) || (cs_n == '0)));
  assert_write_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (dq_oe && !ras_n));
endmodule

bind paged_dram_ctrl paged_dram_ctrl_chk #(
  .CHIP_W(CHIP_W), .ROW_W(ROW_W), .COL_W(COL_W), .TRP(TRP), .TCAS(TCAS)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ras_n (dram_ras_n),
  .cas_n (dram_cas_n),
  .we_n  (dram_we_n),
  .dq_oe (dram_dq_oe),
  .addr  (dram_addr),
  .cs_n  (dram_cs_n),
  .ready (req_ready)
);

// File: tb/paged_dram_ctrl_tb.sv
module paged_dram_ctrl_tb;
  localparam int TRCD = 3, TCAS = 2, TRP = 4, TRAS = 3, TREFI = 120;
  localparam int LAT_IDLE = TRCD + TCAS + 3;
  localparam int LAT_HIT  = TCAS + 3;
  localparam int LAT_MISS = TRP + TRCD + TCAS + 5;
  localparam int NV = 13;
  // {rd, addr[23:0], data (write byte or expected read byte), kind: 0 idle, 1 hit, 2 miss}
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 24'h101403, 8'hA5, 2'd0},
    {1'b0, 24'h101404, 8'h3C, 2'd1},
    {1'b1, 24'h101403, 8'hA5, 2'd1},
    {1'b0, 24'h201403, 8'h77, 2'd2},
    {1'b1, 24'h101404, 8'h3C, 2'd2},
    {1'b0, 24'h101804, 8'h11, 2'd2},
    {1'b1, 24'h101804, 8'h11, 2'd1},
    {1'b1, 24'h201403, 8'h77, 2'd2},
    {1'b0, 24'h000000, 8'hFF, 2'd2},
    {1'b1, 24'h000000, 8'hFF, 2'd1},
    {1'b1, 24'h101403, 8'hA5, 2'd2},
    {1'b0, 24'hF01C07, 8'h5A, 2'd2},
    {1'b1, 24'hF01C07, 8'h5A, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_rd = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic [7:0]  rsp_rdata;
  logic [15:0] dram_cs_n;
  logic [9:0]  dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [7:0]  dram_dq_out, dram_dq_in;

  paged_dram_ctrl #(.TRCD(TRCD), .TCAS(TCAS), .TRP(TRP), .TRAS(TRAS), .TREFI(TREFI)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_rdata(rsp_rdata), .dram_cs_n(dram_cs_n), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  int nchk = 0, nfail = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // DRAM model: small store indexed by low chip, row and column bits
  logic [7:0] mem [256];
  logic [9:0] m_row = '0, m_col = '0;
  logic [3:0] m_chip = '0;
  logic [7:0] m_idx;
  assign m_idx = {m_chip[1:0], m_row[2:0], m_col[2:0]};
  assign dram_dq_in = (!dram_cas_n && dram_we_n) ? mem[m_idx] : 8'h00;

  always @(negedge dram_ras_n) begin
    m_row = dram_addr;
    for (int i = 0; i < 16; i++) if (!dram_cs_n[i]) m_chip = 4'(i);
  end
  always @(negedge dram_cas_n) begin
    m_col = dram_addr;
    if (!dram_we_n) mem[{m_chip[1:0], m_row[2:0], dram_addr[2:0]}] = dram_dq_out;
  end

  // Port monitor
  logic        cur_rd = 1'b0;
  logic [9:0]  cur_row = '0, cur_col = '0;
  logic [7:0]  cur_wdata = '0;
  logic [15:0] exp_cs = '1;
  bit          pras = 1'b1, pcas = 1'b1, in_ref = 1'b0, watch = 1'b0;
  int          ref_cnt = 0, exp_ref_row = 0, ref_lo = 0, first_kind = 0;
  int          ref_prev_cyc = 0, ref_last_cyc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pras && !dram_ras_n) begin
        if (dram_cs_n == '0) begin
          chk(dram_addr == 10'(exp_ref_row), "R8 refresh row", dram_addr, exp_ref_row);
          exp_ref_row++;
          ref_cnt++;
          in_ref = 1'b1;
          ref_lo = 0;
          ref_prev_cyc = ref_last_cyc;
          ref_last_cyc = cyc;
          if (watch && first_kind == 0) first_kind = 1;
        end else begin
          chk(dram_addr == cur_row, "R2 row address", dram_addr, cur_row);
          chk(dram_cs_n == exp_cs, "R1 chip select", dram_cs_n, exp_cs);
          if (watch && first_kind == 0) first_kind = 2;
        end
      end
      if (in_ref) begin
        if (!dram_ras_n) ref_lo++;
        else begin
          chk(ref_lo == TRAS, "R8 refresh width", ref_lo, TRAS);
          in_ref = 1'b0;
        end
      end
      if (pcas && !dram_cas_n) begin
        chk(dram_addr == cur_col, "R3 column address", dram_addr, cur_col);
        chk(dram_we_n == cur_rd, "R5 write enable", dram_we_n, cur_rd);
        if (!cur_rd) chk(dram_dq_oe && dram_dq_out == cur_wdata, "R5 write drive", dram_dq_out, cur_wdata);
        else         chk(!dram_dq_oe, "R5 read no drive", dram_dq_oe, 0);
      end
    end
    pras = dram_ras_n;
    pcas = dram_cas_n;
  end

  int rst_cyc = 0;

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R10 strobes high", {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
    chk(dram_cs_n == '1, "R10 selects high", dram_cs_n, 16'hFFFF);
    chk(!req_ready && !dram_dq_oe, "R10 ready/oe low", {req_ready, dram_dq_oe}, 0);
    exp_ref_row = 0;
    in_ref = 1'b0;
    rst_n = 1'b1;
    rst_cyc = cyc;
  endtask

  task automatic access(input bit rd, input logic [23:0] a, input logic [7:0] wd,
                        output logic [7:0] rdv, output int lat);
    cur_rd = rd;
    cur_row = a[19:10];
    cur_col = a[9:0];
    cur_wdata = wd;
    exp_cs = ~(16'(1) << a[23:20]);
    req_valid = 1'b1;
    req_rd = rd;
    req_addr = a;
    req_wdata = wd;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!req_ready && lat < 400);
    rdv = rsp_rdata;
    if (!req_ready) chk(1'b0, "R4 ready timeout", lat, 0);
  endtask

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 100000) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd_v;
    int lat;
    int base;
    int mark_prev;

    // Refresh timing with the controller idle
    do_reset();
    base = ref_cnt;
    while (ref_cnt < base + 2 && cyc < rst_cyc + 4 * TREFI) @(negedge clk);
    chk(ref_prev_cyc - rst_cyc == TREFI + 2, "R8 first refresh", ref_prev_cyc - rst_cyc, TREFI + 2);
    chk(ref_last_cyc - ref_prev_cyc == TREFI, "R8 refresh interval", ref_last_cyc - ref_prev_cyc, TREFI);

    // Refresh pending in the same cycle a host request arrives
    do_reset();
    repeat (TREFI) @(negedge clk);
    watch = 1'b1;
    first_kind = 0;
    access(1'b0, 24'h200401, 8'h9C, rd_v, lat);
    watch = 1'b0;
    chk(first_kind == 1, "R9 refresh before host", first_kind, 1);
    access(1'b1, 24'h200401, 8'h00, rd_v, lat);
    chk(rd_v == 8'h9C, "R9 data after refresh", rd_v, 8'h9C);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);

    // Vector table
    do_reset();
    mark_prev = ref_cnt;
    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      int mark_now;
      int exp_lat;
      v = VEC[i];
      mark_now = ref_cnt;
      access(v[34], v[33:10], v[9:2], rd_v, lat);
      exp_lat = (v[1:0] == 2'd0) ? LAT_IDLE : (v[1:0] == 2'd1) ? LAT_HIT : LAT_MISS;
      if (v[34]) chk(rd_v == v[9:2], "R4 R5 read data", rd_v, v[9:2]);
      if (ref_cnt == mark_prev) begin
        if (v[1:0] == 2'd0)      chk(lat == exp_lat, "R3 idle latency", lat, exp_lat);
        else if (v[1:0] == 2'd1) chk(lat == exp_lat, "R6 page hit latency", lat, exp_lat);
        else                     chk(lat == exp_lat, "R7 page miss latency", lat, exp_lat);
      end
      mark_prev = mark_now;
    end
    req_valid = 1'b0;

    // Row held open while idle
    base = ref_cnt;
    repeat (3) @(negedge clk);
    if (ref_cnt == base && !in_ref)
      chk(!dram_ras_n && dram_cas_n, "R11 row held open", {dram_ras_n, dram_cas_n}, 2'b01);

    // Refresh closes the open row: next access to the same row pays the row phase
    while (ref_cnt == base && cyc < rst_cyc + 8 * TREFI) @(negedge clk);
    repeat (TRAS + TRP + 2) @(negedge clk);
    access(1'b1, 24'hF01C07, 8'h00, rd_v, lat);
    chk(rd_v == 8'h5A, "R9 data after row closed", rd_v, 8'h5A);
    chk(lat == LAT_IDLE, "R9 row closed by refresh", lat, LAT_IDLE);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule